// File: doc/BRIEF.md
# Indirect Configuration Ownership Semaphore

This block guards two indirect configuration access paths: one aimed downstream and one aimed upstream. Each path has a one-bit ownership flag that a requester takes by reading it. A read that returns 0 while the path is enabled sets the flag after the read. That requester is then expected to use the address/data pair alone, and every later reader sees 1 and waits. The flag drops by itself when the completion input for that direction arrives.

Two host-side register ports reach the block: a primary side and a secondary side. Each port is a single-cycle request with a word address and combinational read data. The primary side owns the downstream path and the secondary side owns the upstream path. A control/status word carries side-effect-free mirrors of both flags, plus an enable bit and a self-response control bit for each direction. While its enable is set, an access to a direction's data word emits a one-clock start pulse for the transaction engine. No further start pulse is issued for that direction until its completion is seen.

Top module: `cfg_own_sem`

## Requirements
- R1: After rst_ni is released, every readable bit is 0 on both ports, and ds_start_o, us_start_o, ds_self_resp_o and us_self_resp_o are all 0.
- R2: Word 1 is the control/status word and both ports can write it. Its writable fields are bit 1 (downstream enable), bit 2 (downstream self-response), bit 9 (upstream enable) and bit 10 (upstream self-response). Bit 0 mirrors the downstream flag and bit 8 mirrors the upstream flag, and every other bit reads 0. ds_self_resp_o follows bit 2 and us_self_resp_o follows bit 10.
- R3: Word 0 is the ownership word: bit 0 is the downstream flag and bit 8 is the upstream flag. A primary read of word 0 with downstream enable set returns the current value and sets the downstream flag from the next cycle. A secondary read of word 0 with upstream enable set does the same for the upstream flag.
- R4: A read of word 0 while that direction's enable is 0 leaves its flag at 0.
- R5: Reads of word 1 from either port never change any flag.
- R6: A completion input clears its direction's flag from the next cycle. If an acquiring read and a completion land in the same cycle, the read returns the old value and the flag stays 0.
- R7: A primary access to word 2 (downstream data) with downstream enable set gives ds_start_o high for exactly the next cycle. A secondary access to word 3 does the same for us_start_o. With the enable at 0, no pulse is issued and the word reads 0.
- R8: After a start pulse, further data accesses issue no pulse until that direction's completion has been seen.
- R9: Writes to word 0 from either port leave both flags unchanged.
- R10: If both ports write word 1 in the same cycle, the primary value is taken.
- R11: An access to the data word of the other direction (secondary to word 2, primary to word 3) issues no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| p_req_i | input | 1 | primary access strobe |
| p_we_i | input | 1 | primary write (1) / read (0) |
| p_addr_i | input | AW | primary word address |
| p_wdata_i | input | DW | primary write data |
| p_rdata_o | output | DW | primary read data, combinational |
| s_req_i | input | 1 | secondary access strobe |
| s_we_i | input | 1 | secondary write (1) / read (0) |
| s_addr_i | input | AW | secondary word address |
| s_wdata_i | input | DW | secondary write data |
| s_rdata_o | output | DW | secondary read data, combinational |
| ds_done_i | input | 1 | downstream transaction complete |
| us_done_i | input | 1 | upstream transaction complete |
| ds_start_o | output | 1 | downstream transaction start pulse |
| us_start_o | output | 1 | upstream transaction start pulse |
| ds_self_resp_o | output | 1 | downstream self-response control level |
| us_self_resp_o | output | 1 | upstream self-response control level |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a 2-bit word address. At those values all four words and every field bit, reserved bits included, can be reached by random addresses and random write data. Random low-rate completions line up with acquiring reads and data accesses often enough to exercise the same-cycle clear priority and the busy window between a start pulse and its completion. Directed sequences cover the simultaneous writes to word 1, the cross-direction data accesses, and the paths with enable off.

// File: rtl/cfg_own_pkg.sv
package cfg_own_pkg;
  localparam int unsigned NDIR = 2;
  localparam int unsigned DIR_DS = 0;
  localparam int unsigned DIR_US = 1;
  // field offsets inside a direction's half-word
  localparam int unsigned F_OWN  = 0;
  localparam int unsigned F_EN   = 1;
  localparam int unsigned F_SELF = 2;
  // word addresses
  localparam int unsigned W_OWN   = 0;
  localparam int unsigned W_CTL   = 1;
  localparam int unsigned W_DATA0 = 2;
endpackage

// File: rtl/own_dir.sv
module own_dir (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic acq_i,
  input  logic dacc_i,
  input  logic done_i,
  output logic own_o,
  output logic busy_o,
  output logic start_o
);
  logic issue;
  assign issue = dacc_i & en_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_o   <= 1'b0;
      busy_o  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      // completion wins over a same-cycle acquire
      own_o   <= done_i ? 1'b0 : (own_o | (acq_i & en_i));
      busy_o  <= issue | (busy_o & ~done_i);
      start_o <= issue;
    end
  end
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          p_wr_i,
  input  logic [DW-1:0] p_wdata_i,
  input  logic          s_wr_i,
  input  logic [DW-1:0] s_wdata_i,
  output logic [1:0]    en_o,
  output logic [1:0]    self_o
);
  import cfg_own_pkg::*;
  localparam int unsigned HALF = DW / 2;

  logic [DW-1:0] wsel;
  assign wsel = p_wr_i ? p_wdata_i : s_wdata_i;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[d]   <= 1'b0;
        self_o[d] <= 1'b0;
      end else if (p_wr_i | s_wr_i) begin
        en_o[d]   <= wsel[d*HALF + F_EN];
        self_o[d] <= wsel[d*HALF + F_SELF];
      end
    end
  end
endmodule

// File: rtl/rd_mux.sv
module rd_mux #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    own_i,
  input  logic [1:0]    en_i,
  input  logic [1:0]    self_i,
  output logic [DW-1:0] rdata_o
);
  import cfg_own_pkg::*;
  localparam int unsigned HALF = DW / 2;

  always_comb begin
    rdata_o = '0;
    for (int d = 0; d < NDIR; d++) begin
      if (addr_i == AW'(W_OWN)) begin
        rdata_o[d*HALF + F_OWN] = own_i[d];
      end else if (addr_i == AW'(W_CTL)) begin
        rdata_o[d*HALF + F_OWN]  = own_i[d];
        rdata_o[d*HALF + F_EN]   = en_i[d];
        rdata_o[d*HALF + F_SELF] = self_i[d];
      end
    end
  end
endmodule

// File: rtl/cfg_own_sem.sv
module cfg_own_sem #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          p_req_i,
  input  logic          p_we_i,
  input  logic [AW-1:0] p_addr_i,
  input  logic [DW-1:0] p_wdata_i,
  output logic [DW-1:0] p_rdata_o,
  input  logic          s_req_i,
  input  logic          s_we_i,
  input  logic [AW-1:0] s_addr_i,
  input  logic [DW-1:0] s_wdata_i,
  output logic [DW-1:0] s_rdata_o,
  input  logic          ds_done_i,
  input  logic          us_done_i,
  output logic          ds_start_o,
  output logic          us_start_o,
  output logic          ds_self_resp_o,
  output logic          us_self_resp_o
);
  import cfg_own_pkg::*;

  logic [1:0]          req, we, acq, dacc, own_q, busy_q, start, done, en, self_r;
  logic [1:0][AW-1:0]  addr;

  assign req  = {s_req_i, p_req_i};
  assign we   = {s_we_i, p_we_i};
  assign addr = {s_addr_i, p_addr_i};
  assign done = {us_done_i, ds_done_i};

  // side d owns direction d
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign acq[d]  = req[d] & ~we[d] & (addr[d] == AW'(W_OWN));
    assign dacc[d] = req[d] & (addr[d] == AW'(W_DATA0 + d));

    own_dir u_own (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en[d]),
      .acq_i   (acq[d]),
      .dacc_i  (dacc[d]),
      .done_i  (done[d]),
      .own_o   (own_q[d]),
      .busy_o  (busy_q[d]),
      .start_o (start[d])
    );
  end

  ctl_regs #(.DW(DW)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .p_wr_i    (p_req_i & p_we_i & (p_addr_i == AW'(W_CTL))),
    .p_wdata_i (p_wdata_i),
    .s_wr_i    (s_req_i & s_we_i & (s_addr_i == AW'(W_CTL))),
    .s_wdata_i (s_wdata_i),
    .en_o      (en),
    .self_o    (self_r)
  );

  rd_mux #(.DW(DW), .AW(AW)) u_rd_p (
    .addr_i (p_addr_i), .own_i (own_q), .en_i (en), .self_i (self_r), .rdata_o (p_rdata_o)
  );
  rd_mux #(.DW(DW), .AW(AW)) u_rd_s (
    .addr_i (s_addr_i), .own_i (own_q), .en_i (en), .self_i (self_r), .rdata_o (s_rdata_o)
  );

  assign ds_start_o     = start[DIR_DS];
  assign us_start_o     = start[DIR_US];
  assign ds_self_resp_o = self_r[DIR_DS];
  assign us_self_resp_o = self_r[DIR_US];
endmodule

// File: rtl/cfg_own_sem_chk.sv
module cfg_own_sem_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] acq,
  input logic [1:0] dacc,
  input logic [1:0] en,
  input logic [1:0] own_q,
  input logic [1:0] busy_q,
  input logic [1:0] start,
  input logic [1:0] done
);
  for (genvar d = 0; d < 2; d++) begin : g_chk
    // R3
    a_r3_acquire_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(own_q[d]) |-> $past(acq[d] && en[d]));
    // R6
    a_r6_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done[d] |=> !own_q[d]);
    // R7
    a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start[d] |=> !start[d]);
    // R7
    a_r7_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(start[d]) |-> $past(dacc[d] && en[d]));
    // R8
    a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q[d] && !done[d]) |=> !start[d]);
  end
endmodule

bind cfg_own_sem cfg_own_sem_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .acq    (acq),
  .dacc   (dacc),
  .en     (en),
  .own_q  (own_q),
  .busy_q (busy_q),
  .start  (start),
  .done   (done)
);

// File: tb/cfg_own_sem_tb.sv
`timescale 1ns/1ps
module cfg_own_sem_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        p_req = 0, p_we = 0, s_req = 0, s_we = 0, ds_done = 0, us_done = 0;
  logic [1:0]  p_addr = 0, s_addr = 0;
  logic [15:0] p_wdata = 0, s_wdata = 0;
  logic [15:0] p_rdata, s_rdata;
  logic        ds_start, us_start, ds_self, us_self;

  int total = 0, bad = 0;
  bit finished = 0;

  bit [1:0] m_own, m_busy, m_en, m_self, m_start;

  always #10 clk = ~clk;

  cfg_own_sem u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .p_req_i(p_req), .p_we_i(p_we), .p_addr_i(p_addr), .p_wdata_i(p_wdata), .p_rdata_o(p_rdata),
    .s_req_i(s_req), .s_we_i(s_we), .s_addr_i(s_addr), .s_wdata_i(s_wdata), .s_rdata_o(s_rdata),
    .ds_done_i(ds_done), .us_done_i(us_done),
    .ds_start_o(ds_start), .us_start_o(us_start),
    .ds_self_resp_o(ds_self), .us_self_resp_o(us_self)
  );

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    logic [15:0] r = '0;
    for (int d = 0; d < 2; d++) begin
      if (a == 2'd0) r[d*8] = m_own[d];
      else if (a == 2'd1) begin
        r[d*8] = m_own[d]; r[d*8+1] = m_en[d]; r[d*8+2] = m_self[d];
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update(input logic pr, pw, input logic [1:0] pa, input logic [15:0] pwd,
                              input logic sr, sw, input logic [1:0] sa, input logic [15:0] swd,
                              input logic dd, ud);
    logic [1:0] rq, w, dn, a0;
    logic [1:0][1:0] ad;
    logic acq, dac, iss;
    logic [15:0] wv;
    rq = {sr, pr}; w = {sw, pw}; ad = {sa, pa}; dn = {ud, dd};
    for (int d = 0; d < 2; d++) begin
      acq = rq[d] & ~w[d] & (ad[d] == 2'd0) & m_en[d];
      dac = rq[d] & (ad[d] == 2'(2 + d)) & m_en[d];
      iss = dac & ~m_busy[d];
      m_own[d]   = dn[d] ? 1'b0 : (m_own[d] | acq);
      m_busy[d]  = iss | (m_busy[d] & ~dn[d]);
      m_start[d] = iss;
    end
    a0 = {sr & sw & (sa == 2'd1), pr & pw & (pa == 2'd1)};
    if (a0 != 0) begin
      wv = a0[0] ? pwd : swd;
      m_en   = {wv[9], wv[1]};
      m_self = {wv[10], wv[2]};
    end
  endtask

  task automatic step(input string tag,
                      input logic pr, pw, input logic [1:0] pa, input logic [15:0] pwd,
                      input logic sr, sw, input logic [1:0] sa, input logic [15:0] swd,
                      input logic dd = 0, ud = 0);
    @(negedge clk);
    p_req = pr; p_we = pw; p_addr = pa; p_wdata = pwd;
    s_req = sr; s_we = sw; s_addr = sa; s_wdata = swd;
    ds_done = dd; us_done = ud;
    #2;
    check({tag, " p_rdata"}, p_rdata, exp_rd(pa));
    check({tag, " s_rdata"}, s_rdata, exp_rd(sa));
    @(posedge clk);
    model_update(pr, pw, pa, pwd, sr, sw, sa, swd, dd, ud);
    #2;
    check({tag, " starts"}, {ds_start, us_start}, {m_start[0], m_start[1]});
    check({tag, " self"}, {ds_self, us_self}, {m_self[0], m_self[1]});
    p_req = 0; s_req = 0; ds_done = 0; us_done = 0;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 2'd1, 16'h0, 0, 0, 2'd1, 16'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    step("R1", 1, 0, 2'd1, 0, 1, 0, 2'd0, 0);
    check("R1 own word", p_rdata, 16'h0);
    // R4 acquire with enables off
    step("R4", 1, 0, 2'd0, 0, 1, 0, 2'd0, 0);
    step("R4", 1, 0, 2'd1, 0, 1, 0, 2'd1, 0);
    check("R4 flags", p_rdata & 16'h0101, 16'h0);
    // R2 field layout
    step("R2", 1, 1, 2'd1, 16'hFFFF, 0, 0, 2'd1, 0);
    step("R2", 0, 0, 2'd1, 0, 1, 0, 2'd1, 0);
    check("R2 ctl", s_rdata, 16'h0606);
    // R10 simultaneous writes
    step("R10", 1, 1, 2'd1, 16'h0002, 1, 1, 2'd1, 16'h0600);
    step("R10", 1, 0, 2'd1, 0, 0, 0, 2'd1, 0);
    check("R10 ctl", p_rdata, 16'h0002);
    step("R2", 1, 1, 2'd1, 16'h0202, 0, 0, 2'd1, 0);
    // R5 ctl reads have no side effect
    step("R5", 1, 0, 2'd1, 0, 1, 0, 2'd1, 0);
    step("R5", 1, 0, 2'd1, 0, 1, 0, 2'd1, 0);
    check("R5 flags", p_rdata & 16'h0101, 16'h0);
    // R6 acquire and completion in same cycle
    step("R6", 1, 0, 2'd0, 0, 1, 0, 2'd0, 0, 1, 1);
    check("R6 read old", p_rdata, 16'h0);
    step("R6", 1, 0, 2'd1, 0, 0, 0, 2'd1, 0);
    check("R6 no grant", p_rdata & 16'h0101, 16'h0);
    // R3 acquire from each side
    step("R3", 1, 0, 2'd0, 0, 0, 0, 2'd1, 0);
    step("R3", 0, 0, 2'd1, 0, 1, 0, 2'd0, 0);
    step("R3", 1, 0, 2'd0, 0, 0, 0, 2'd1, 0);
    check("R3 both owned", p_rdata, 16'h0101);
    // R9 writes to own word ignored
    step("R9", 1, 1, 2'd0, 16'h0000, 1, 1, 2'd0, 16'h0000);
    step("R9", 1, 0, 2'd1, 0, 0, 0, 2'd1, 0);
    check("R9 flags kept", p_rdata & 16'h0101, 16'h0101);
    // R6 completion clears
    step("R6", 0, 0, 2'd1, 0, 0, 0, 2'd1, 0, 1, 1);
    step("R6", 1, 0, 2'd1, 0, 0, 0, 2'd1, 0);
    check("R6 cleared", p_rdata & 16'h0101, 16'h0);
    // R7 start pulse, R8 no restart while busy
    step("R7", 1, 0, 2'd2, 0, 1, 1, 2'd3, 16'h1234);
    check("R7 pulse", {ds_start, us_start}, 2'b11);
    step("R7", 0, 0, 2'd1, 0, 0, 0, 2'd1, 0);
    check("R7 one cycle", {ds_start, us_start}, 2'b00);
    step("R8", 1, 1, 2'd2, 0, 1, 0, 2'd3, 0);
    check("R8 busy", {ds_start, us_start}, 2'b00);
    step("R8", 0, 0, 2'd1, 0, 0, 0, 2'd1, 0, 1, 1);
    step("R8", 1, 0, 2'd2, 0, 1, 0, 2'd3, 0);
    check("R8 after done", {ds_start, us_start}, 2'b11);
    step("R11", 0, 0, 2'd1, 0, 0, 0, 2'd1, 0, 1, 1);
    // R11 cross-direction data access
    step("R11", 1, 0, 2'd3, 0, 1, 0, 2'd2, 0);
    check("R11 no start", {ds_start, us_start}, 2'b00);
    // R7 disabled path
    step("R7", 1, 1, 2'd1, 16'h0000, 0, 0, 2'd1, 0);
    step("R7", 1, 0, 2'd2, 0, 1, 0, 2'd3, 0);
    check("R7 disabled", {ds_start, us_start}, 2'b00);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      step("RND", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 99) < 30), 2'($urandom),
           16'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 99) < 30),
           2'($urandom), 16'($urandom),
           1'($urandom_range(0, 99) < 8), 1'($urandom_range(0, 99) < 8));
    end
    idle("END");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule